// File: doc/BRIEF.md
# Extended Message Interrupt Vector Engine

This block keeps the per-vector state for extended message-signalled interrupts. It holds a memory-mapped table, with a message address, a message data word and a vector control word for every vector. It also holds a packed array of pending bits and three capability words that tell software where the table and the pending array sit. Software reaches all of these over a simple word-wide register bus. Internal logic raises per-vector requests on `irq_req`. The engine turns each request into a memory-write message request that carries the address and the data stored in that vector's table entry.

Two things can hold a vector back: its own mask bit, or the function-wide mask in message control. A request on a held-back vector is recorded as pending. The message goes out once the vector becomes eligible again. A master enable in message control gates everything. While it is clear, requests are discarded. When several vectors are eligible at once, the lowest-numbered one goes first. The message leaves through a single-entry valid/ready port.

All structures share one byte-addressed space on the register bus. The capability words sit at 0x0, 0x4 and 0x8. The table starts at byte offset `TBL_OFF` and the pending array starts at `PBA_OFF`. Both offsets are multiples of 8.

Top module: `msgint_vector_engine`

## Requirements
- R1: Capability word 0 (address 0x0) reads {msg control[15:0], next pointer[7:0], 8'h11}. Message control bits 10:0 read NUM_VEC-1. Bit 15 is the master enable and bit 14 is the function mask. Both reset to 0, and they are the only writable bits of the word.
- R2: Word 0x4 reads {TBL_OFF[31:3], TBL_SEL[2:0]} and word 0x8 reads {PBA_OFF[31:3], PBA_SEL[2:0]}. Writes to these words are ignored.
- R3: Table entry n sits at TBL_OFF+16n, with these fields: +0 address low, +4 address high, +8 data, +12 vector control. The first three are read/write and reset to 0. Vector control bit 0 is the mask and resets to 1. Its other bits read 0.
- R4: Vector n's pending bit sits in the 64-bit word at PBA_OFF+(n/64)*8, at bit n%64. Bits 31:0 of that word read at the word's address and bits 63:32 read at the address plus 4. The array is read-only, and bus writes to it change no bit.
- R5: A request that arrives while the master enable is clear is discarded. It sets no pending bit and produces no message.
- R6: A request on a vector that is masked, either by its own bit or by the function mask, sets the pending bit and sends nothing. When the vector becomes unmasked, its message is issued and its pending bit clears.
- R7: msg_addr is {address high, address low} and msg_data is the stored data word. Both are taken from the table entry unchanged.
- R8: Among eligible vectors, the lowest-numbered vector is served first. With msg_ready held high, one message is accepted every cycle.
- R9: While msg_valid is high and msg_ready is low, msg_valid, msg_addr and msg_data stay unchanged.
- R10: A read sampled at a clock edge returns its data on bus_rdata after that edge. Addresses that map to no structure read 0.
- R11: Suppose an unmasked vector's request is sampled at edge k while the output slot is empty. Then msg_valid rises after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_addr | output | 64 | Message write address |
| msg_data | output | 32 | Message write data |

## Verification
The table is swept in full: every field of every entry is written with a distinct index-derived value and read back. A wrong stride or a swapped field then shows up as a wrong value. The request patterns are these:
- A request while disabled, which separates discarding from pending.
- All vectors at once under their own masks, which fills the pending array bit for bit.
- All vectors released together by clearing the function mask, which exposes the service order and the message contents one per cycle.
- Two simultaneous requests under backpressure, which shows priority, hold stability and issue latency.

Writes of zeros and ones to the pending array separate a read-only array from a writable one.

// File: rtl/msgint_pkg.sv
package msgint_pkg;

  localparam logic [7:0] CAP_ID = 8'h11;

  // field selected by byte offset bits 3:2 inside a 16-byte table entry
  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_VCTRL   = 2'd3
  } fld_e;

endpackage

// File: rtl/msgint_vec_table.sv
module msgint_vec_table
  import msgint_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   acc_idx,
  input  fld_e               acc_fld,
  input  logic               wr_en,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic [IDX_W-1:0]   sel_idx,
  output logic [63:0]        sel_addr,
  output logic [31:0]        sel_data,
  output logic [NUM_VEC-1:0] mask_o
);

  logic [31:0] lo_a  [NUM_VEC];
  logic [31:0] hi_a  [NUM_VEC];
  logic [31:0] dat_a [NUM_VEC];

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_ent
    logic        wr_hit;
    logic [31:0] lo_q, hi_q, dat_q;
    logic        msk_q;

    assign wr_hit = wr_en && (acc_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        dat_q <= '0;
        msk_q <= 1'b1;
      end else if (wr_hit) begin
        case (acc_fld)
          FLD_ADDR_LO: lo_q  <= wdata;
          FLD_ADDR_HI: hi_q  <= wdata;
          FLD_DATA:    dat_q <= wdata;
          default:     msk_q <= wdata[0];
        endcase
      end
    end

    assign lo_a[gi]   = lo_q;
    assign hi_a[gi]   = hi_q;
    assign dat_a[gi]  = dat_q;
    assign mask_o[gi] = msk_q;
  end

  always_comb begin
    case (acc_fld)
      FLD_ADDR_LO: rdata = lo_a[acc_idx];
      FLD_ADDR_HI: rdata = hi_a[acc_idx];
      FLD_DATA:    rdata = dat_a[acc_idx];
      default:     rdata = {31'd0, mask_o[acc_idx]};
    endcase
  end

  assign sel_addr = {hi_a[sel_idx], lo_a[sel_idx]};
  assign sel_data = dat_a[sel_idx];

endmodule

// File: rtl/msgint_pend_array.sv
module msgint_pend_array #(
  parameter int NUM_VEC = 16,
  parameter int DW_CNT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o,
  input  logic [29:0]        rd_dw,
  output logic [31:0]        rd_data
);

  logic [NUM_VEC-1:0]  pend_q, pend_n;
  logic [DW_CNT*32-1:0] pad;

  // a new request in the same cycle as a clear keeps the bit set
  always_comb pend_n = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_n;
  end

  always_comb begin
    pad = '0;
    pad[NUM_VEC-1:0] = pend_q;
    rd_data = '0;
    for (int k = 0; k < DW_CNT; k++) begin
      if (rd_dw == 30'(k)) rd_data = pad[k*32 +: 32];
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/msgint_low_pick.sv
module msgint_low_pick #(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_VEC-1:0] req,
  output logic [NUM_VEC-1:0] grant,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);

  logic [NUM_VEC:0] below;
  assign below[0] = 1'b0;

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_chain
    assign below[gi+1] = below[gi] | req[gi];
    assign grant[gi]   = req[gi] & ~below[gi];
  end

  assign any = below[NUM_VEC];

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/msgint_vector_engine.sv
module msgint_vector_engine
  import msgint_pkg::*;
#(
  parameter int          NUM_VEC  = 16,
  parameter int          ADDR_W   = 16,
  parameter logic [31:0] TBL_OFF  = 32'h0000_0100,
  parameter logic [2:0]  TBL_SEL  = 3'd0,
  parameter logic [31:0] PBA_OFF  = 32'h0000_0200,
  parameter logic [2:0]  PBA_SEL  = 3'd2,
  parameter logic [7:0]  NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_VEC-1:0] irq_req,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);

  localparam int          IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int          PBA_QW  = (NUM_VEC + 63) / 64;
  localparam int          PBA_DW  = PBA_QW * 2;
  localparam logic [31:0] TBL_END = TBL_OFF + 32'(16 * NUM_VEC);
  localparam logic [31:0] PBA_END = PBA_OFF + 32'(8 * PBA_QW);
  localparam logic [31:0] CAP_END = 32'd12;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  // address decode
  logic [31:0]      a32, tbl_rel, pba_rel;
  logic             hit_cap, hit_tbl, hit_pba;
  logic [IDX_W-1:0] tbl_idx;
  fld_e             tbl_fld;
  logic [29:0]      pba_dw;

  always_comb begin
    a32     = 32'(bus_addr);
    tbl_rel = a32 - TBL_OFF;
    pba_rel = a32 - PBA_OFF;
    hit_cap = (a32 < CAP_END);
    hit_tbl = (a32 >= TBL_OFF) && (a32 < TBL_END);
    hit_pba = (a32 >= PBA_OFF) && (a32 < PBA_END);
    tbl_idx = tbl_rel[IDX_W+3:4];
    tbl_fld = fld_e'(tbl_rel[3:2]);
    pba_dw  = pba_rel[31:2];
  end

  // message control: enable and function mask
  logic ctl_en, ctl_fm, ctl_wr;
  assign ctl_wr = bus_wr && hit_cap && (a32[3:2] == 2'd0);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctl_en <= 1'b0;
      ctl_fm <= 1'b0;
    end else if (ctl_wr) begin
      ctl_en <= bus_wdata[31];
      ctl_fm <= bus_wdata[30];
    end
  end

  logic [31:0] cap0, cap1, cap2;
  assign cap0 = {ctl_en, ctl_fm, 3'b000, 11'(NUM_VEC - 1), NEXT_PTR, CAP_ID};
  assign cap1 = {TBL_OFF[31:3], TBL_SEL};
  assign cap2 = {PBA_OFF[31:3], PBA_SEL};

  // vector table
  logic [NUM_VEC-1:0] mask_v;
  logic [31:0]        tbl_rdata, sel_data;
  logic [63:0]        sel_addr;
  logic [IDX_W-1:0]   sel_idx;

  msgint_vec_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_i),
    .acc_idx  (tbl_idx),
    .acc_fld  (tbl_fld),
    .wr_en    (bus_wr && hit_tbl),
    .wdata    (bus_wdata),
    .rdata    (tbl_rdata),
    .sel_idx  (sel_idx),
    .sel_addr (sel_addr),
    .sel_data (sel_data),
    .mask_o   (mask_v)
  );

  // pending array and selection
  logic [NUM_VEC-1:0] pend_q, elig, grant, pend_set, pend_clr;
  logic [31:0]        pba_rdata;
  logic               any_elig, take, slot_free;

  assign pend_set = irq_req & {NUM_VEC{ctl_en}};
  assign elig     = pend_q & ~mask_v & {NUM_VEC{ctl_en & ~ctl_fm}};

  msgint_low_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
    .req   (elig),
    .grant (grant),
    .idx   (sel_idx),
    .any   (any_elig)
  );

  logic valid_q, valid_n;
  assign slot_free = !valid_q || msg_ready;
  assign take      = slot_free && any_elig;
  assign pend_clr  = grant & {NUM_VEC{take}};

  msgint_pend_array #(.NUM_VEC(NUM_VEC), .DW_CNT(PBA_DW)) u_pend (
    .clk     (clk),
    .rst_n   (rst_i),
    .set_i   (pend_set),
    .clr_i   (pend_clr),
    .pend_o  (pend_q),
    .rd_dw   (pba_dw),
    .rd_data (pba_rdata)
  );

  // output slot
  logic [63:0] maddr_q;
  logic [31:0] mdata_q;

  always_comb valid_n = take | (valid_q & ~msg_ready);

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      maddr_q <= '0;
      mdata_q <= '0;
    end else if (take) begin
      maddr_q <= sel_addr;
      mdata_q <= sel_data;
    end
  end

  assign msg_valid = valid_q;
  assign msg_addr  = maddr_q;
  assign msg_data  = mdata_q;

  // read path
  logic [31:0] rd_n, rdata_q;

  always_comb begin
    rd_n = '0;
    if (hit_cap) begin
      case (a32[3:2])
        2'd0:    rd_n = cap0;
        2'd1:    rd_n = cap1;
        2'd2:    rd_n = cap2;
        default: rd_n = '0;
      endcase
    end else if (hit_tbl) begin
      rd_n = tbl_rdata;
    end else if (hit_pba) begin
      rd_n = pba_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_n;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/msgint_vector_engine_chk.sv
module msgint_vector_engine_chk #(
  parameter int NUM_VEC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic [NUM_VEC-1:0] pend_q,
  input logic [NUM_VEC-1:0] mask_v,
  input logic [NUM_VEC-1:0] grant,
  input logic               ctl_en,
  input logic               ctl_fm
);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R6
  issue_from_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(ctl_en && !ctl_fm && ((pend_q & ~mask_v) != '0)));

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_vec
    // R5
    no_pend_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[gi]) |-> $past(ctl_en));

    // R6
    clear_only_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[gi]) |-> $past(!mask_v[gi] && ctl_en && !ctl_fm));
  end

endmodule

bind msgint_vector_engine msgint_vector_engine_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .pend_q    (pend_q),
  .mask_v    (mask_v),
  .grant     (grant),
  .ctl_en    (ctl_en),
  .ctl_fm    (ctl_fm)
);

// File: tb/tb_msgint_vector_engine.sv
`timescale 1ns/1ps
module tb_msgint_vector_engine;

  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NV-1:0] irq_req = '0;
  logic          msg_valid;
  logic          msg_ready = 1'b0;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;

  always #2.5 clk = ~clk;

  msgint_vector_engine #(.NUM_VEC(NV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // captured messages
  int          mon_cnt = 0;
  logic [63:0] mon_addr [32];
  logic [31:0] mon_data [32];

  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready && mon_cnt < 32) begin
      mon_addr[mon_cnt] = msg_addr;
      mon_data[mon_cnt] = msg_data;
      mon_cnt = mon_cnt + 1;
    end
  end

  function automatic logic [31:0] lo_of(int i);  return 32'hFEE0_0000 + 32'(i * 16); endfunction
  function automatic logic [31:0] hi_of(int i);  return 32'h0000_0010 + 32'(i);      endfunction
  function automatic logic [31:0] dat_of(int i); return 32'h0000_4000 + 32'(i * 3);  endfunction
  function automatic logic [15:0] ent(int i, int f); return 16'(32'h100 + i * 16 + f * 4); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [NV-1:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(16'h0, d); check("R1 cap0 reset", 64'(d), 64'h000F_0011);
    rd(16'h4, d); check("R2 table locator", 64'(d), 64'h0000_0100);
    rd(16'h8, d); check("R2 pending locator", 64'(d), 64'h0000_0202);
    errs = 0;
    for (int i = 0; i < NV; i++) begin
      rd(ent(i, 3), d); if (d !== 32'd1) errs++;
      rd(ent(i, 2), d); if (d !== 32'd0) errs++;
    end
    check("R3 vector control resets masked", 64'(errs), 64'd0);
    rd(16'h200, d); check("R4 pending reset", 64'(d), 64'd0);
    check("R9 no message after reset", 64'(msg_valid), 64'd0);

    // table sweep
    for (int i = 0; i < NV; i++) begin
      wr(ent(i, 0), lo_of(i));
      wr(ent(i, 1), hi_of(i));
      wr(ent(i, 2), dat_of(i));
    end
    errs = 0;
    for (int i = 0; i < NV; i++) begin
      rd(ent(i, 0), d); if (d !== lo_of(i))  errs++;
      rd(ent(i, 1), d); if (d !== hi_of(i))  errs++;
      rd(ent(i, 2), d); if (d !== dat_of(i)) errs++;
    end
    check("R3 table sweep readback", 64'(errs), 64'd0);
    wr(ent(0, 3), 32'hFFFF_FFFE);
    rd(ent(0, 3), d); check("R3 vector control upper bits read 0", 64'(d), 64'd0);
    wr(ent(0, 3), 32'h1);

    // R5: disabled request discarded
    pulse(16'h0008);
    repeat (3) @(negedge clk);
    rd(16'h200, d); check("R5 disabled request leaves no pending", 64'(d), 64'd0);
    wr(16'h0, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rd(16'h200, d); check("R5 no latent pending after enable", 64'(d), 64'd0);
    check("R5 no message", 64'(msg_valid), 64'd0);

    // R6: all masked, all requested
    pulse('1);
    repeat (3) @(negedge clk);
    rd(16'h200, d); check("R4 all pending low word", 64'(d), 64'h0000_FFFF);
    rd(16'h204, d); check("R4 pending high word", 64'(d), 64'd0);
    check("R6 masked vectors send nothing", 64'(msg_valid), 64'd0);

    // function mask held while own masks drop
    wr(16'h0, 32'hC000_0000);
    for (int i = 0; i < NV; i++) wr(ent(i, 3), 32'h0);
    repeat (3) @(negedge clk);
    check("R6 function mask blocks", 64'(msg_valid), 64'd0);
    rd(16'h200, d); check("R6 pending kept under function mask", 64'(d), 64'h0000_FFFF);

    msg_ready = 1'b1;
    mon_cnt = 0;
    wr(16'h0, 32'h8000_0000);
    repeat (24) @(negedge clk);
    check("R8 all sixteen delivered", 64'(mon_cnt), 64'(NV));
    errs = 0;
    for (int i = 0; i < NV; i++) begin
      if (mon_addr[i] !== {hi_of(i), lo_of(i)}) errs++;
      if (mon_data[i] !== dat_of(i)) errs++;
    end
    check("R7 R8 ascending order and unchanged contents", 64'(errs), 64'd0);
    rd(16'h200, d); check("R6 pending cleared after issue", 64'(d), 64'd0);

    // backpressure, priority, latency
    msg_ready = 1'b0;
    mon_cnt = 0;
    @(negedge clk);
    irq_req = 16'h0084;
    @(negedge clk);
    irq_req = '0;
    check("R11 not yet valid one edge after request", 64'(msg_valid), 64'd0);
    @(negedge clk);
    check("R11 valid two edges after request", 64'(msg_valid), 64'd1);
    check("R8 lowest vector first", msg_addr, {hi_of(2), lo_of(2)});
    repeat (4) @(negedge clk);
    check("R9 valid held", 64'(msg_valid), 64'd1);
    check("R9 address held", msg_addr, {hi_of(2), lo_of(2)});
    check("R9 data held", 64'(msg_data), 64'(dat_of(2)));
    msg_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 two delivered", 64'(mon_cnt), 64'd2);
    check("R8 second is vector 7", 64'(mon_data[1]), 64'(dat_of(7)));

    // R4: pending array ignores writes
    wr(ent(9, 3), 32'h1);
    pulse(16'h0200);
    repeat (2) @(negedge clk);
    wr(16'h200, 32'h0);
    rd(16'h200, d); check("R4 zero write ignored", 64'(d), 64'h0000_0200);
    wr(16'h200, 32'hFFFF_FFFF);
    wr(16'h204, 32'hFFFF_FFFF);
    rd(16'h200, d); check("R4 ones write ignored", 64'(d), 64'h0000_0200);
    rd(16'h204, d); check("R4 high word unchanged", 64'(d), 64'd0);
    mon_cnt = 0;
    wr(ent(9, 3), 32'h0);
    repeat (4) @(negedge clk);
    check("R6 replay on unmask", 64'(mon_cnt), 64'd1);
    check("R7 replayed data", 64'(mon_data[0]), 64'(dat_of(9)));

    // R1/R2 writable bits, R10 unmapped reads
    wr(16'h4, 32'hFFFF_FFFF);
    rd(16'h4, d); check("R2 locator write ignored", 64'(d), 64'h0000_0100);
    wr(16'h0, 32'hFFFF_FFFF);
    rd(16'h0, d); check("R1 only enable and function mask writable", 64'(d), 64'hC00F_0011);
    rd(16'h0C, d); check("R10 unmapped below table", 64'(d), 64'd0);
    rd(16'h300, d); check("R10 unmapped above pending", 64'(d), 64'd0);

    finished = 1;
    finish_run();
  end

endmodule